// File: doc/BRIEF.md
# Bunch-by-Bunch Beam Position Feedback Processor

This block closes a fast correction loop inside a single bunch train. For each bunch it receives two converter samples: a signed position-difference value and an unsigned charge (sum) value. It divides the position by the charge so that the correction does not depend on bunch intensity. It then scales the result by a feedback gain and subtracts it from the kick already in force. The updated kick is registered as a signed word for the kicker amplifier's converter.

Because the kick is held and accumulated, later bunches in a train keep the whole correction built up from earlier ones. A train trigger resets the held kick to zero, so the first bunch of every train passes uncorrected. The same trigger latches the gain for the whole train. A per-bunch strobe starts each computation. An enable input can blank the drive word while the computed kick stays visible on a diagnostic output.

Top module: `bunch_fb_proc`

## Requirements
- R1: After reset, dac_out, diag_out and dac_valid are zero and the latched gain is zero, so a bunch measured before any train_start leaves the kick at zero.
- R2: dac_valid is high for exactly one cycle, on the sixth rising edge, where the edge that samples sample_valid high counts as the first. This is within the limit of 8 processing cycles.
- R3: The normalised position is q = floor(|pos_in| * 1024 / chg_in), clamped to 4095 when the quotient does not fit in 12 bits.
- R4: The bunch term is t = floor(q * gain / 256), and it carries the sign of pos_in. The new kick is the previous kick minus the signed term, so corrections accumulate along the train.
- R5: The kick saturates at +8191 and -8192 instead of wrapping.
- R6: A train_start high at a rising edge sets the kick to zero at that edge and cancels any computation in flight, which then never raises dac_valid. This holds also when train_start falls on the edge where that result would have been written.
- R7: gain_in is latched only on an edge where train_start is high. Changes to gain_in at other times have no effect on the current train.
- R8: A bunch whose chg_in is zero or below chg_min adds a zero term: the kick is held unchanged, and dac_valid still pulses at the usual time.
- R9: While fb_enable is low, dac_out is zero and diag_out still shows the computed kick. While fb_enable is high, dac_out equals diag_out.
- R10: A sample_valid that arrives while a computation is in flight, without train_start, is ignored.
- R11: A sample_valid on the same edge as train_start is accepted as the first bunch of the new train. It is computed from a zero kick with the gain latched on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Train trigger: clears the kick, latches the gain |
| sample_valid | input | 1 | Per-bunch strobe that launches a computation |
| pos_in | input | 14 | Signed position-difference sample |
| chg_in | input | 14 | Unsigned charge sample |
| chg_min | input | 14 | Charge threshold below which no correction is added |
| gain_in | input | 12 | Unsigned gain, 8 fractional bits |
| fb_enable | input | 1 | High drives the kick onto dac_out |
| dac_out | output | 14 | Signed drive word to the kicker converter |
| dac_valid | output | 1 | One-cycle pulse when a new kick is written |
| diag_out | output | 14 | Signed computed kick, shown whatever fb_enable is |

## Verification
Two actions can land on the same clock edge: the train trigger, which zeroes the kick, and the write-back of a bunch result that is still in the divider. The bench lines up train_start twice. Once it falls in the middle of a division. Once it falls on the exact edge where the result would be written, counted edge by edge from the sampling of the strobe. In both cases the test passes only if dac_valid stays low and both output words read zero afterwards. A further case puts the trigger and a bunch strobe on the same edge and expects a fresh first-bunch result computed with the newly latched gain.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
   // per-bunch attributes carried alongside the quotient
   typedef struct packed {
      logic neg;   // position sample was negative
      logic low;   // charge too small to normalise
   } bunch_tag_t;
endpackage

// File: rtl/bfp_recip_div.sv
module bfp_recip_div #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 14,
   parameter int Q_W   = 12,
   parameter int BPC   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [Q_W-1:0]   quo
);
   localparam int ITER = Q_W / BPC;
   localparam int R_W  = DEN_W + 1;
   localparam int CW   = $clog2(ITER) + 1;

   if (Q_W % BPC != 0) begin : g_bad_split
      $error("Q_W must be a multiple of BPC");
   end
   if (NUM_W - Q_W > R_W) begin : g_bad_num
      $error("dividend head wider than remainder");
   end

   logic [R_W-1:0]   rem_q;
   logic [Q_W-1:0]   sh_q, q_q;
   logic [DEN_W-1:0] den_q;
   logic             ovf_q;
   logic [CW-1:0]    cnt_q;
   logic             ovf_in;

   assign ovf_in = (den == '0) || (R_W'(num[NUM_W-1:Q_W]) >= R_W'(den));

   logic [R_W-1:0] r_ch  [BPC+1];
   logic [Q_W-1:0] sh_ch [BPC+1];
   logic [Q_W-1:0] q_ch  [BPC+1];

   assign r_ch[0]  = rem_q;
   assign sh_ch[0] = sh_q;
   assign q_ch[0]  = q_q;

   for (genvar k = 0; k < BPC; k++) begin : g_step
      logic [R_W-1:0] trial;
      logic           fits;
      assign trial       = {r_ch[k][R_W-2:0], sh_ch[k][Q_W-1]};
      assign fits        = trial >= R_W'(den_q);
      assign r_ch[k+1]   = fits ? trial - R_W'(den_q) : trial;
      assign sh_ch[k+1]  = {sh_ch[k][Q_W-2:0], 1'b0};
      assign q_ch[k+1]   = {q_ch[k][Q_W-2:0], fits};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         rem_q <= '0;
         sh_q  <= '0;
         q_q   <= '0;
         den_q <= '0;
         ovf_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         done  <= 1'b0;
         rem_q <= R_W'(num[NUM_W-1:Q_W]);
         sh_q  <= num[Q_W-1:0];
         q_q   <= '0;
         den_q <= den;
         ovf_q <= ovf_in;
         cnt_q <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else if (busy) begin
         rem_q <= r_ch[BPC];
         sh_q  <= sh_ch[BPC];
         q_q   <= q_ch[BPC];
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CW'(ITER - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end

   assign quo = ovf_q ? '1 : q_q;

   // R3: a quotient that fits keeps the remainder below the divisor
   a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ovf_q) |-> (rem_q < R_W'(den_q)));
   // R2: completion is a single-cycle pulse
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/bfp_kick.sv
module bfp_kick #(
   parameter int Q_W       = 12,
   parameter int GAIN_W    = 12,
   parameter int GAIN_FRAC = 8,
   parameter int OUT_W     = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    upd,
   input  logic [Q_W-1:0]          quo,
   input  bfp_pkg::bunch_tag_t     tag,
   input  logic [GAIN_W-1:0]       gain,
   output logic signed [OUT_W-1:0] kick,
   output logic                    valid
);
   localparam int PROD_W = Q_W + GAIN_W;
   localparam int TERM_W = PROD_W - GAIN_FRAC;
   localparam int SUM_W  = TERM_W + 2;
   localparam int MAXI   = (1 << (OUT_W - 1)) - 1;
   localparam int MINI   = -(1 << (OUT_W - 1));

   if (SUM_W <= OUT_W) begin : g_bad_sum
      $error("sum path narrower than output");
   end

   logic [PROD_W-1:0]        prod;
   logic [TERM_W-1:0]        term;
   logic signed [TERM_W:0]   sterm;
   logic signed [SUM_W-1:0]  sum;
   logic signed [OUT_W-1:0]  kick_q, next_k;

   assign prod  = PROD_W'(quo) * PROD_W'(gain);
   assign term  = prod[PROD_W-1:GAIN_FRAC];
   assign sterm = tag.neg ? -$signed({1'b0, term}) : $signed({1'b0, term});
   assign sum   = SUM_W'(kick_q) - SUM_W'(sterm);

   always_comb begin
      if (tag.low)
         next_k = kick_q;
      else if (sum > SUM_W'(MAXI))
         next_k = OUT_W'(MAXI);
      else if (sum < SUM_W'(MINI))
         next_k = OUT_W'(MINI);
      else
         next_k = OUT_W'(sum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kick_q <= '0;
         valid  <= 1'b0;
      end else if (clr) begin
         kick_q <= '0;
         valid  <= 1'b0;
      end else begin
         valid <= upd;
         if (upd) kick_q <= next_k;
      end
   end

   assign kick = kick_q;

   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (kick_q == '0 && !valid));
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && tag.low && !clr) |=> (kick_q == $past(kick_q)));
   a_r5_no_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !tag.low && !tag.neg && !clr) |=> (kick_q <= $past(kick_q)));
   a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !tag.low && tag.neg && !clr) |=> (kick_q >= $past(kick_q)));
endmodule

// File: rtl/bunch_fb_proc.sv
module bunch_fb_proc #(
   parameter int POS_W        = 14,
   parameter int CHG_W        = 14,
   parameter int GAIN_W       = 12,
   parameter int GAIN_FRAC    = 8,
   parameter int NORM_FRAC    = 10,
   parameter int Q_W          = 12,
   parameter int BITS_PER_CYC = 3,
   parameter int OUT_W        = 14,
   parameter int MAX_LAT      = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    train_start,
   input  logic                    sample_valid,
   input  logic signed [POS_W-1:0] pos_in,
   input  logic [CHG_W-1:0]        chg_in,
   input  logic [CHG_W-1:0]        chg_min,
   input  logic [GAIN_W-1:0]       gain_in,
   input  logic                    fb_enable,
   output logic signed [OUT_W-1:0] dac_out,
   output logic                    dac_valid,
   output logic signed [OUT_W-1:0] diag_out
);
   import bfp_pkg::*;

   localparam int NUM_W = POS_W + NORM_FRAC;
   localparam int ITER  = Q_W / BITS_PER_CYC;
   localparam int LAT   = ITER + 2;

   if (LAT > MAX_LAT) begin : g_bad_lat
      $error("processing latency exceeds budget");
   end

   logic [GAIN_W-1:0]       gain_q;
   bunch_tag_t              tag_q;
   logic [POS_W-1:0]        pos_mag;
   logic [NUM_W-1:0]        num;
   logic                    low_chg, accept;
   logic                    div_busy, div_done;
   logic [Q_W-1:0]          quo;
   logic signed [OUT_W-1:0] kick;

   assign pos_mag = pos_in[POS_W-1] ? POS_W'(-pos_in) : POS_W'(pos_in);
   assign num     = {pos_mag, {NORM_FRAC{1'b0}}};
   assign low_chg = (chg_in == '0) || (chg_in < chg_min);
   assign accept  = sample_valid && (!div_busy || train_start);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_q <= '0;
         tag_q  <= '0;
      end else begin
         if (train_start) gain_q <= gain_in;
         if (accept) begin
            tag_q.neg <= pos_in[POS_W-1];
            tag_q.low <= low_chg;
         end
      end
   end

   bfp_recip_div #(
      .NUM_W(NUM_W), .DEN_W(CHG_W), .Q_W(Q_W), .BPC(BITS_PER_CYC)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .start(accept), .abort(train_start),
      .num(num), .den(chg_in), .busy(div_busy), .done(div_done), .quo(quo)
   );

   bfp_kick #(
      .Q_W(Q_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(OUT_W)
   ) u_kick (
      .clk(clk), .rst_n(rst_n), .clr(train_start), .upd(div_done),
      .quo(quo), .tag(tag_q), .gain(gain_q), .kick(kick), .valid(dac_valid)
   );

   assign diag_out = kick;
   assign dac_out  = fb_enable ? kick : '0;

   a_r7_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !train_start |=> $stable(gain_q));
   a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> div_busy);
   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      dac_valid |-> !div_busy || $past(train_start));
   a_r9_drive_match: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_out != '0) |-> (dac_out == diag_out));
endmodule

// File: tb/bunch_fb_proc_tb.sv
module bunch_fb_proc_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic train_start = 1'b0, sample_valid = 1'b0, fb_enable = 1'b1;
   logic signed [13:0] pos_in = '0;
   logic [13:0] chg_in = '0, chg_min = 14'd50;
   logic [11:0] gain_in = '0;
   logic signed [13:0] dac_out, diag_out;
   logic dac_valid;

   int n_chk = 0, n_fail = 0, exp_k = 0, cur_gain = 0, lat;

   always #4 clk = ~clk;

   bunch_fb_proc u_dut (
      .clk(clk), .rst_n(rst_n), .train_start(train_start), .sample_valid(sample_valid),
      .pos_in(pos_in), .chg_in(chg_in), .chg_min(chg_min), .gain_in(gain_in),
      .fb_enable(fb_enable), .dac_out(dac_out), .dac_valid(dac_valid), .diag_out(diag_out));

   localparam int NV = 6;
   localparam int VP [NV] = '{100, -300, 8000, -1, 2000, -8192};
   localparam int VC [NV] = '{1000, 2000, 8000, 16383, 500, 9000};

   function automatic int model(int prev, int p, int c, int g, int cmin);
      int mag, q, t, k;
      if (c == 0 || c < cmin) return prev;
      mag = (p < 0) ? -p : p;
      q = (mag * 1024) / c;
      if (q > 4095) q = 4095;
      t = (q * g) / 256;
      k = (p < 0) ? prev + t : prev - t;
      if (k > 8191) k = 8191;
      if (k < -8192) k = -8192;
      return k;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic new_train(int g);
      @(negedge clk);
      train_start = 1'b1; gain_in = 12'(g);
      @(negedge clk);
      train_start = 1'b0;
      cur_gain = g; exp_k = 0;
   endtask

   task automatic bunch(int p, int c, output int l);
      @(negedge clk);
      pos_in = 14'(p); chg_in = 14'(c); sample_valid = 1'b1;
      l = 0;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         sample_valid = 1'b0;
         if (dac_valid && l == 0) l = i;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 dac", int'(dac_out), 0);
      chk("R1 diag", int'(diag_out), 0);
      chk("R1 valid", int'(dac_valid), 0);
      rst_n = 1'b1;
      bunch(1000, 1000, lat);
      chk("R1 zero gain", int'(diag_out), 0);

      // table walk: R2 R3 R4
      new_train(256);
      for (int v = 0; v < NV; v++) begin
         bunch(VP[v], VC[v], lat);
         exp_k = model(exp_k, VP[v], VC[v], cur_gain, 50);
         chk("R2 latency", lat, 6);
         chk("R4 kick", int'(diag_out), exp_k);
         chk("R9 dac", int'(dac_out), exp_k);
      end

      // R6 train start clears
      new_train(512);
      chk("R6 cleared", int'(diag_out), 0);
      // R7 gain change mid-train ignored
      gain_in = 12'd100;
      bunch(600, 1200, lat);
      exp_k = model(0, 600, 1200, 512, 50);
      chk("R7 latched gain", int'(diag_out), exp_k);

      // R8 low and zero charge
      chg_min = 14'd500;
      bunch(3000, 400, lat);
      chk("R8 held", int'(diag_out), exp_k);
      chk("R8 valid", lat, 6);
      chg_min = 14'd0;
      bunch(3000, 0, lat);
      chk("R8 zero chg", int'(diag_out), exp_k);
      chg_min = 14'd50;

      // R5 and R3 clamp
      new_train(4095);
      bunch(8000, 2000, lat);
      chk("R5 neg sat", int'(diag_out), -8192);
      bunch(-8000, 2000, lat);
      bunch(-8000, 2000, lat);
      chk("R5 pos sat", int'(diag_out), 8191);
      exp_k = 8191;

      // R9 enable off
      fb_enable = 1'b0;
      new_train(256);
      bunch(-500, 1000, lat);
      exp_k = model(0, -500, 1000, 256, 50);
      chk("R9 dac blank", int'(dac_out), 0);
      chk("R9 diag", int'(diag_out), exp_k);
      fb_enable = 1'b1;
      @(negedge clk);
      chk("R9 dac on", int'(dac_out), exp_k);

      // R10 second strobe while busy
      begin
         int pulses = 0;
         @(negedge clk);
         pos_in = 14'sd200; chg_in = 14'd1000; sample_valid = 1'b1;
         @(negedge clk);
         sample_valid = 1'b0;
         @(negedge clk);
         pos_in = 14'sd4000; chg_in = 14'd100; sample_valid = 1'b1;
         @(negedge clk);
         sample_valid = 1'b0;
         for (int i = 0; i < 12; i++) begin
            if (dac_valid) pulses++;
            @(negedge clk);
         end
         exp_k = model(exp_k, 200, 1000, 256, 50);
         chk("R10 pulses", pulses, 1);
         chk("R10 value", int'(diag_out), exp_k);
      end

      // R6 abort in flight
      begin
         int pulses = 0;
         @(negedge clk);
         pos_in = 14'sd300; chg_in = 14'd900; sample_valid = 1'b1;
         @(negedge clk);
         sample_valid = 1'b0;
         @(negedge clk);
         train_start = 1'b1;
         @(negedge clk);
         train_start = 1'b0;
         for (int i = 0; i < 10; i++) begin
            if (dac_valid) pulses++;
            @(negedge clk);
         end
         chk("R6 abort pulses", pulses, 0);
         chk("R6 abort diag", int'(diag_out), 0);
      end

      // R6 trigger on the write-back edge
      bunch(700, 1000, lat);
      chk("R6 pre", int'(diag_out) != 0, 1);
      begin
         int pulses = 0;
         @(negedge clk);
         pos_in = 14'sd300; chg_in = 14'd900; sample_valid = 1'b1;
         @(negedge clk);            // after first edge
         sample_valid = 1'b0;
         repeat (4) @(negedge clk); // after fifth edge
         train_start = 1'b1;
         @(negedge clk);            // after sixth edge
         train_start = 1'b0;
         if (dac_valid) pulses++;
         chk("R6 collide diag", int'(diag_out), 0);
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (dac_valid) pulses++;
         end
         chk("R6 collide pulses", pulses, 0);
      end

      // R11 strobe together with trigger
      @(negedge clk);
      train_start = 1'b1; gain_in = 12'd128; sample_valid = 1'b1;
      pos_in = -14'sd900; chg_in = 14'd3000;
      lat = 0;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         train_start = 1'b0; sample_valid = 1'b0;
         if (dac_valid && lat == 0) lat = i;
      end
      chk("R11 latency", lat, 6);
      chk("R11 value", int'(diag_out), model(0, -900, 3000, 128, 50));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule